// File: doc/BRIEF.md
# Center-Aligned PWM Gate Generator with Narrow-Pulse Suppression

This block produces one gate-drive level for a motor power stage. An up/down counter sweeps from zero to a programmable top value and back, so each PWM pulse is centred on the point where the count returns to zero. A compare value arrives from an outside current loop. The block turns it into a gate waveform with a selectable polarity.

Some pulses, high or low, are too short to pass cleanly through an isolator and gate driver. The block removes them. It holds the output at the matching rail for the whole period. It also treats a compare of zero, or a compare at or above the top value, as an explicit rail case. The compare, top, minimum width and polarity are all sampled once, at the bottom of the count. The rail decision is made at that same moment. As a result, the shape of a period never changes partway through it. A status output tells the control loop when a period has been pinned to a rail.

Top module: `dspwm_gate`

## Requirements
- R1: After each bottom, the count runs 0, 1, …, T, T−1, …, 1 and then returns to 0. T is the top value sampled at that bottom, so one period lasts 2·T clock ticks.
- R2: When no rail is forced and the polarity is not inverted, the gate is high on the rising half while count < C and on the falling half while count ≤ C. This gives exactly 2·C contiguous high ticks per period.
- R3: A compare C of 0 holds the non-inverted gate low for the whole period.
- R4: A compare C ≥ T (with T > 0) holds the non-inverted gate high for the whole period.
- R5: When the polarity input is 1, every level is inverted, including the rail levels of R3, R4, R6 and R7.
- R6: If the high width 2·C is below the minimum width W, the non-inverted gate stays low for the whole period. This rule is checked before R7.
- R7: Otherwise, if the low width 2·(T−C) is below W, the non-inverted gate stays high for the whole period.
- R8: Compare, top, minimum width and polarity are taken only on the edge where the count becomes 0. Changing them at any other time has no effect on the running period.
- R9: The rail output is 1 for every tick of a period in which R3, R4, R6 or R7 holds the gate at a rail, and 0 for every tick of a normal period.
- R10: During reset, the count is 0, the gate is 0 and the rail output is 1. The first clock edge after reset is released starts a period using the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| top_i | input | CNT_W | Top value of the count, sampled at the bottom |
| cmp_i | input | CNT_W | Compare value from the current loop, sampled at the bottom |
| min_w_i | input | CNT_W+1 | Minimum pulse width in ticks, sampled at the bottom |
| invert_i | input | 1 | 1 selects inverted gate polarity, sampled at the bottom |
| gate_o | output | 1 | Registered gate-drive level |
| rail_o | output | 1 | 1 while the current period is held at a rail |
| count_o | output | CNT_W | Current counter value |

## Verification
The hardest case to reach from the ports is an input change that lands in the middle of a period. The rule is that nothing may move until the next bottom.

The bench first locks onto a bottom by watching the count. At the peak tick it then changes the compare, the polarity, the minimum width and the top all together. It checks that every remaining tick still follows the values sampled at the start of the period.

Boundary compares are placed one step either side of each suppression limit. These include C = 1 against C = 2 and T−1 against T−2. The bench also uses a very small top at which both pulses are narrow, which exercises the priority of the high-pulse rule.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
    typedef enum logic [1:0] {
        DRV_RUN  = 2'd0,
        DRV_LOW  = 2'd1,
        DRV_HIGH = 2'd2
    } drv_mode_e;
endpackage

// File: rtl/dspwm_counter.sv
module dspwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             up_nxt_o,
    output logic             bottom_nxt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
    } ctr_s;

    ctr_s s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.up) begin
            if (s_q.cnt >= top_i) begin
                s_d.cnt = (top_i == '0) ? '0 : s_q.cnt - 1'b1;
                s_d.up  = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (s_d.cnt == '0) begin
            s_d.up = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, up: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o        = s_q.cnt;
    assign cnt_nxt_o    = s_d.cnt;
    assign up_nxt_o     = s_d.up;
    assign bottom_nxt_o = (s_d.cnt == '0);

    // R1: the falling slope never sits at zero
    a_r1_no_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.up |-> (s_q.cnt != '0));

    // R1: the count never passes the top it is given
    a_r1_within_top: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt <= top_i) || (s_q.cnt == '0));
endmodule

// File: rtl/dspwm_judge.sv
module dspwm_judge
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W:0]   min_w_i,
    output drv_mode_e        mode_o
);
    localparam int WW = CNT_W + 1;

    logic [CNT_W-1:0] gap;
    logic [WW-1:0]    hi_w;
    logic [WW-1:0]    lo_w;

    always_comb begin
        gap  = top_i - cmp_i;
        hi_w = {cmp_i, 1'b0};
        lo_w = {gap, 1'b0};
        if ((cmp_i == '0) || (hi_w < min_w_i)) begin
            mode_o = DRV_LOW;
        end else if ((cmp_i >= top_i) || (lo_w < min_w_i)) begin
            mode_o = DRV_HIGH;
        end else begin
            mode_o = DRV_RUN;
        end
    end
endmodule

// File: rtl/dspwm_gate.sv
module dspwm_gate
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W:0]   min_w_i,
    input  logic             invert_i,
    output logic             gate_o,
    output logic             rail_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] top;
        logic [CNT_W-1:0] cmp;
        logic             inv;
        drv_mode_e        mode;
        logic             gate;
    } act_s;

    act_s s_q, s_d;

    logic [CNT_W-1:0] cnt_nxt;
    logic             up_nxt;
    logic             bottom_nxt;
    drv_mode_e        mode_new;
    logic             lvl;

    dspwm_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .top_i        (s_q.top),
        .cnt_o        (count_o),
        .cnt_nxt_o    (cnt_nxt),
        .up_nxt_o     (up_nxt),
        .bottom_nxt_o (bottom_nxt)
    );

    dspwm_judge #(.CNT_W(CNT_W)) u_judge (
        .top_i   (top_i),
        .cmp_i   (cmp_i),
        .min_w_i (min_w_i),
        .mode_o  (mode_new)
    );

    always_comb begin
        s_d = s_q;
        if (bottom_nxt) begin
            s_d.top  = top_i;
            s_d.cmp  = cmp_i;
            s_d.inv  = invert_i;
            s_d.mode = mode_new;
        end
        case (s_d.mode)
            DRV_HIGH: lvl = 1'b1;
            DRV_LOW:  lvl = 1'b0;
            default:  lvl = up_nxt ? (cnt_nxt < s_d.cmp) : (cnt_nxt <= s_d.cmp);
        endcase
        s_d.gate = lvl ^ s_d.inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{top: '0, cmp: '0, inv: 1'b0, mode: DRV_LOW, gate: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_o = s_q.gate;
    assign rail_o = (s_q.mode != DRV_RUN);

    // R1: each tick moves the count by one, or holds it at zero
    a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == $past(count_o) + 1'b1) || ($past(count_o) == count_o + 1'b1) ||
        ((count_o == '0) && ($past(count_o) == '0)));

    // R8: active settings stay frozen away from the bottom
    a_r8_frozen_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != '0) |-> ($stable(s_q.cmp) && $stable(s_q.top) && $stable(s_q.inv)
                             && $stable(s_q.mode)));

    // R9: a railed period never toggles the gate
    a_r9_rail_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o != '0) && rail_o) |-> $stable(gate_o));

    // R6 / R7: a normal period always has room for both pulses
    a_r6_r7_run_margin: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == DRV_RUN) |-> ((s_q.cmp != '0) && (s_q.cmp < s_q.top)));
endmodule

// File: tb/tb_dspwm_gate.sv
`timescale 1ns/1ps
module tb_dspwm_gate;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] top_i;
    logic [CW-1:0] cmp_i;
    logic [CW:0]   min_w_i;
    logic          invert_i;
    logic          gate_o;
    logic          rail_o;
    logic [CW-1:0] count_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dspwm_gate #(.CNT_W(CW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .top_i    (top_i),
        .cmp_i    (cmp_i),
        .min_w_i  (min_w_i),
        .invert_i (invert_i),
        .gate_o   (gate_o),
        .rail_o   (rail_o),
        .count_o  (count_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // 0 = normal, 1 = low rail, 2 = high rail (R3, R4, R6, R7)
    function automatic int exp_mode(input int t, input int c, input int m);
        if (c == 0 || 2 * c < m) return 1;
        if (c >= t || 2 * (t - c) < m) return 2;
        return 0;
    endfunction

    task automatic sync_bottom();
        int n;
        n = 0;
        @(negedge clk);
        while (count_o != '0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic test_reset();
        rst_n    = 1'b0;
        top_i    = CW'(6);
        cmp_i    = CW'(3);
        min_w_i  = (CW+1)'(4);
        invert_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(count_o == '0, "R10", "count in reset", int'(count_o), 0);
        chk(gate_o == 1'b0, "R10", "gate in reset", int'(gate_o), 0);
        chk(rail_o == 1'b1, "R10", "rail in reset", int'(rail_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gate_o == 1'b1 && rail_o == 1'b0, "R10", "first tick gate/rail",
            int'({gate_o, rail_o}), 2);
        @(negedge clk);
        chk(count_o == CW'(1), "R10", "second tick count", int'(count_o), 1);
    endtask

    // one period with given settings; cmid >= 0 changes inputs at the peak (R8)
    task automatic play(input int t, input int c, input int m, input bit inv,
                        input string req, input int cmid);
        int md, cnt_err, gate_err, rail_err, highs, exp_hi;
        top_i    = CW'(t);
        cmp_i    = CW'(c);
        min_w_i  = (CW+1)'(m);
        invert_i = inv;
        sync_bottom();
        md = exp_mode(t, c, m);
        cnt_err = 0; gate_err = 0; rail_err = 0; highs = 0;
        for (int k = 0; k < 2 * t; k++) begin
            int  ec;
            bit  lvl;
            ec  = (k <= t) ? k : 2 * t - k;
            if (md == 2)      lvl = 1'b1;
            else if (md == 1) lvl = 1'b0;
            else              lvl = (k < t) ? (ec < c) : (ec <= c);
            if (int'(count_o) != ec) cnt_err++;
            if (gate_o != (lvl ^ inv)) gate_err++;
            if (rail_o != (md != 0)) rail_err++;
            highs += int'(gate_o);
            if (cmid >= 0 && k == t) begin
                cmp_i    = CW'(cmid);
                invert_i = !inv;
                min_w_i  = '0;
                top_i    = CW'(t + 3);
            end
            @(negedge clk);
        end
        exp_hi = (md == 2) ? 2 * t : (md == 1) ? 0 : 2 * c;
        if (inv) exp_hi = 2 * t - exp_hi;
        chk(cnt_err == 0, "R1", "count sequence mismatches", cnt_err, 0);
        chk(count_o == '0, "R1", "count at period end", int'(count_o), 0);
        chk(gate_err == 0, req, "gate tick mismatches", gate_err, 0);
        chk(highs == exp_hi, req, "high ticks", highs, exp_hi);
        chk(rail_err == 0, "R9", "rail tick mismatches", rail_err, 0);
    endtask

    initial begin
        test_reset();
        play(40, 10, 4, 1'b0, "R2", -1);
        play(7, 3, 4, 1'b0, "R1", -1);
        play(40, 0, 4, 1'b0, "R3", -1);
        play(40, 40, 4, 1'b0, "R4", -1);
        play(40, 55, 4, 1'b0, "R4", -1);
        play(40, 1, 4, 1'b0, "R6", -1);
        play(40, 2, 4, 1'b0, "R6", -1);
        play(40, 1, 0, 1'b0, "R6", -1);
        play(40, 9, 20, 1'b0, "R6", -1);
        play(2, 1, 4, 1'b0, "R6", -1);
        play(40, 39, 4, 1'b0, "R7", -1);
        play(40, 38, 4, 1'b0, "R7", -1);
        play(40, 30, 21, 1'b0, "R7", -1);
        play(40, 10, 4, 1'b1, "R5", -1);
        play(40, 0, 4, 1'b1, "R5", -1);
        play(40, 40, 4, 1'b1, "R5", -1);
        play(40, 12, 4, 1'b0, "R8", 25);
        play(20, 1, 4, 1'b0, "R8", 10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule